// File: doc/BRIEF.md
# Paced Buffer-to-Memory DMA with Ownership Parking

This block moves bytes from a sector buffer into one of three target memories: sound sample RAM, program RAM or the shared work RAM. Software picks the target with a 3-bit destination code, loads a start address and a byte count, then pulses a start strobe. The engine spends a fixed number of clock cycles per byte and hands out bytes only in bursts of eight, so its write port is busy in short regular spurts rather than continuously.

Program RAM and the unsplit work RAM can be owned by another processor. While the other side holds the target, the engine parks with its count and address intact, and picks up again when ownership is handed back. On resume its cycle mark moves forward to the present time, never back. A write to the destination field retargets a running transfer on the fly and zeroes the address register; dropping the data-output enable stops everything at once. The end of a transfer raises a sticky end flag, a one-cycle done pulse and, when enabled, an interrupt pulse.

Top module: `paced_dma`

## Requirements
- R1: After reset no memory is written, the count output reads all ones and the end flag is low.
- R2: Destination code 4 writes sound RAM (`mem_we` bit 0), code 5 writes program RAM (bit 1), code 7 writes work RAM (bit 2); any other code performs no writes. At most one enable is high.
- R3: With a cost of 16 cycles per byte and 8-byte bursts, the first write appears 113 cycles after the clock edge that samples the start pulse (or the edge that resumes a parked transfer).
- R4: Every burst is at most 8 back-to-back writes, and consecutive full bursts start 128 cycles apart.
- R5: A loaded count N moves N+1 bytes; when fewer than 8 count units remain the last burst writes the remainder plus one. Afterwards the count reads all ones, the end flag is set and a one-cycle done pulse is produced.
- R6: The write address starts at the address register value and rises by one per byte written.
- R7: A program-RAM transfer started while `prg_own` is high writes nothing until `prg_own` falls, then follows the R3 timing from that edge.
- R8: When the owner takes the target mid-transfer the burst in flight completes, no further burst starts while ownership is held, and remaining bytes continue after release.
- R9: For code 7, with `mem_split` high `mem_sel0`=1 gives `work_half`=01 and 0 gives 10; with `mem_split` low `work_half`=11 and `mem_sel0`=1 means the other side owns the work RAM.
- R10: On release the cycle mark never moves backward: a park shorter than the mark's lead leaves the next burst exactly 128 cycles after the previous one.
- R11: A destination write re-evaluates the target of a started transfer, clears the address to 0 and keeps the remaining count; an invalid code stops writes.
- R12: With `out_en` low both running and parked transfers are dropped, start pulses are ignored and no writes occur.
- R13: The interrupt pulse accompanies the done pulse only when `irq_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock |
| rst_n | input | 1 | Active-low reset |
| dest_wr | input | 1 | Destination field write strobe |
| dest_in | input | 3 | Destination code |
| mem_split | input | 1 | Work RAM split into two banks |
| mem_sel0 | input | 1 | Bank select (split) or other-side ownership (unsplit) |
| prg_own | input | 1 | Other side holds program RAM |
| out_en | input | 1 | Data-output enable |
| xfer_start | input | 1 | Start pulse |
| cnt_in | input | CNT_W | Byte count minus one |
| addr_wr | input | 1 | Address register write strobe |
| addr_in | input | ADDR_W | Address register value |
| irq_en | input | 1 | End interrupt enable |
| src_data | input | 8 | Buffer byte offered this cycle |
| src_rd | output | 1 | Buffer byte consumed |
| mem_we | output | 3 | One-hot write enable: sound, program, work |
| work_half | output | 2 | Work RAM bank: 01 bank0, 10 bank1, 11 whole |
| mem_addr | output | ADDR_W | Write address |
| mem_data | output | 8 | Write data |
| cnt_out | output | CNT_W | Remaining count |
| end_flag | output | 1 | Sticky transfer-end flag |
| xfer_done | output | 1 | Done pulse |
| irq | output | 1 | End interrupt pulse |

## Verification
The properties assume the strobes `dest_wr`, `addr_wr` and `xfer_start` never coincide and that `xfer_start` is a single-cycle pulse; the stimulus issues each strobe in its own cycle from the falling edge. They also assume ownership only changes for the target actually in use, which the stimulus respects by toggling `prg_own` or `mem_sel0` only during the matching transfer. The short-park case is timed so release lands inside the cycle mark's lead, exercising the no-rewind rule.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_PARK} run_e;
   typedef enum logic [2:0] {TG_NONE, TG_SOUND, TG_PROG, TG_WB0, TG_WB1, TG_WALL} tgt_e;
   localparam logic [2:0] CODE_SOUND = 3'd4;
   localparam logic [2:0] CODE_PROG  = 3'd5;
   localparam logic [2:0] CODE_WORK  = 3'd7;
   localparam int N_MEM = 3;
endpackage

// File: rtl/pdma_route.sv
module pdma_route
   import pdma_pkg::*;
(
   input  logic [2:0] code,
   input  logic       split,
   input  logic       sel0,
   input  logic       prg_own,
   input  tgt_e       held,
   output tgt_e       pick,
   output logic       pick_blocked,
   output logic       held_owned
);
   always_comb begin
      case (code)
         CODE_SOUND: pick = TG_SOUND;
         CODE_PROG:  pick = TG_PROG;
         CODE_WORK:  pick = split ? (sel0 ? TG_WB0 : TG_WB1) : TG_WALL;
         default:    pick = TG_NONE;
      endcase
   end

   assign pick_blocked = ((pick == TG_PROG) && prg_own) || ((pick == TG_WALL) && sel0);
   assign held_owned   = ((held == TG_PROG) && prg_own) ||
                         ((held == TG_WALL) && sel0 && !split);
endmodule

// File: rtl/pdma_pacer.sv
module pdma_pacer #(
   parameter int CYC_W = 16,
   parameter int COST  = 16,
   parameter int BURST = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync,
   input  logic ff,
   input  logic charge,
   output logic ready
);
   localparam int CHARGE = COST * BURST;
   localparam int THRESH = COST * (BURST - 1);
   localparam logic signed [CYC_W-1:0] THR = CYC_W'(THRESH);
   localparam logic [CYC_W-1:0] STEP = CYC_W'(CHARGE);

   initial begin
      assert (COST >= 1) else $error("pacer: COST must be positive");
      assert (BURST >= 1) else $error("pacer: BURST must be positive");
      assert (CYC_W > $clog2(CHARGE) + 2) else $error("pacer: CYC_W too narrow");
   end

   logic [CYC_W-1:0] now_q, mark_q;
   logic signed [CYC_W-1:0] gap;

   assign gap = $signed(now_q - mark_q);

   generate
      if (BURST == 1) begin : g_single
         assign ready = (gap > 0);
      end else begin : g_multi
         assign ready = (gap > THR);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         now_q  <= '0;
         mark_q <= '0;
      end else begin
         now_q <= now_q + 1'b1;
         if (sync) mark_q <= now_q;
         else if (ff) begin
            if (gap > 0) mark_q <= now_q;
         end else if (charge) mark_q <= mark_q + STEP;
      end
   end

   assert_mark_no_rewind_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sync) |-> ($signed(mark_q - $past(mark_q)) >= 0));
   assert_charge_needs_credit_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      charge |-> ready);
endmodule

// File: rtl/pdma_burst.sv
module pdma_burst #(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 16,
   parameter int BURST  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CNT_W-1:0]  cnt_in,
   input  logic              abort,
   input  logic              go,
   input  logic              addr_wr,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              addr_clr,
   output logic              busy,
   output logic              wr,
   output logic              done,
   output logic              charge,
   output logic [ADDR_W-1:0] addr,
   output logic [CNT_W-1:0]  cnt
);
   localparam int LW = $clog2(BURST + 1);
   localparam logic [CNT_W-1:0] BCNT = CNT_W'(BURST);
   localparam logic [LW-1:0] BLEN = LW'(BURST);

   initial begin
      assert (CNT_W > $clog2(BURST)) else $error("burst: CNT_W too narrow");
   end

   logic [LW-1:0] left_q;
   logic          fin_q;
   logic          last;

   assign busy   = (left_q != '0);
   assign wr     = busy;
   assign done   = (left_q == LW'(1)) && fin_q;
   assign last   = (cnt < BCNT);
   assign charge = go && !last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         fin_q  <= 1'b0;
         cnt    <= '1;
      end else if (load) begin
         left_q <= '0;
         fin_q  <= 1'b0;
         cnt    <= cnt_in;
      end else if (abort) begin
         left_q <= '0;
         fin_q  <= 1'b0;
      end else if (go) begin
         if (last) begin
            left_q <= LW'(cnt) + LW'(1);
            fin_q  <= 1'b1;
         end else begin
            left_q <= BLEN;
            fin_q  <= 1'b0;
            cnt    <= cnt - BCNT;
         end
      end else if (busy) begin
         left_q <= left_q - LW'(1);
         if (done) begin
            cnt   <= '1;
            fin_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr <= '0;
      else if (addr_wr) addr <= addr_in;
      else if (addr_clr) addr <= '0;
      else if (wr) addr <= addr + 1'b1;
   end

   assert_burst_len_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      left_q <= BLEN);
   assert_addr_step_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      wr && !addr_wr && !addr_clr |=> addr == $past(addr) + 1'b1);
   assert_count_ones_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      done && !load && !abort |=> cnt == '1);
endmodule

// File: rtl/paced_dma.sv
module paced_dma
   import pdma_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 16,
   parameter int CYC_W  = 16,
   parameter int COST   = 16,
   parameter int BURST  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dest_wr,
   input  logic [2:0]        dest_in,
   input  logic              mem_split,
   input  logic              mem_sel0,
   input  logic              prg_own,
   input  logic              out_en,
   input  logic              xfer_start,
   input  logic [CNT_W-1:0]  cnt_in,
   input  logic              addr_wr,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              irq_en,
   input  logic [7:0]        src_data,
   output logic              src_rd,
   output logic [2:0]        mem_we,
   output logic [1:0]        work_half,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_data,
   output logic [CNT_W-1:0]  cnt_out,
   output logic              end_flag,
   output logic              xfer_done,
   output logic              irq
);
   run_e       state_q, nxt_state, eval_state;
   tgt_e       held_q, nxt_held, pick;
   logic [2:0] dest_q;
   logic       reinit_q, xfer_on_q;
   logic       pick_blocked, held_owned;
   logic       ready, bbusy, bwr, bdone, bcharge;
   logic       fire, go, ff, sync, load, abort;

   pdma_route u_route (
      .code(dest_q), .split(mem_split), .sel0(mem_sel0), .prg_own(prg_own),
      .held(held_q), .pick(pick), .pick_blocked(pick_blocked), .held_owned(held_owned)
   );

   pdma_pacer #(.CYC_W(CYC_W), .COST(COST), .BURST(BURST)) u_pacer (
      .clk(clk), .rst_n(rst_n), .sync(sync), .ff(ff), .charge(bcharge), .ready(ready)
   );

   pdma_burst #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BURST(BURST)) u_burst (
      .clk(clk), .rst_n(rst_n), .load(load), .cnt_in(cnt_in), .abort(abort), .go(go),
      .addr_wr(addr_wr), .addr_in(addr_in), .addr_clr(fire),
      .busy(bbusy), .wr(bwr), .done(bdone), .charge(bcharge), .addr(mem_addr), .cnt(cnt_out)
   );

   assign fire  = reinit_q && !bbusy;
   assign sync  = out_en && xfer_start;
   assign load  = sync;
   assign abort = !out_en || xfer_start;
   assign go    = out_en && !xfer_start && !reinit_q && (state_q == ST_RUN) && !bbusy && ready;

   assign eval_state = (pick == TG_NONE) ? ST_IDLE : (pick_blocked ? ST_PARK : ST_RUN);

   always_comb begin
      nxt_state = state_q;
      nxt_held  = held_q;
      if (!out_en) begin
         nxt_state = ST_IDLE;
      end else if (xfer_start) begin
         nxt_state = eval_state;
         nxt_held  = pick;
      end else if (bdone) begin
         nxt_state = ST_IDLE;
      end else if (fire) begin
         if (xfer_on_q) begin
            nxt_state = eval_state;
            nxt_held  = pick;
         end
      end else begin
         case (state_q)
            ST_RUN:  if (!bbusy && !ready && held_owned) nxt_state = ST_PARK;
            ST_PARK: if (!held_owned) nxt_state = ST_RUN;
            default: nxt_state = state_q;
         endcase
      end
   end

   assign ff = out_en && !xfer_start && (state_q == ST_PARK) && (nxt_state == ST_RUN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         held_q    <= TG_NONE;
         dest_q    <= '0;
         reinit_q  <= 1'b0;
         xfer_on_q <= 1'b0;
         end_flag  <= 1'b0;
         xfer_done <= 1'b0;
         irq       <= 1'b0;
      end else begin
         state_q <= nxt_state;
         held_q  <= nxt_held;
         if (fire) reinit_q <= 1'b0;
         if (dest_wr) begin
            dest_q   <= dest_in;
            reinit_q <= 1'b1;
         end
         xfer_done <= 1'b0;
         irq       <= 1'b0;
         if (!out_en) begin
            xfer_on_q <= 1'b0;
         end else if (xfer_start) begin
            xfer_on_q <= 1'b1;
            end_flag  <= 1'b0;
         end else if (bdone) begin
            xfer_on_q <= 1'b0;
            end_flag  <= 1'b1;
            xfer_done <= 1'b1;
            irq       <= irq_en;
         end
      end
   end

   logic [N_MEM-1:0] tgt_hit;
   assign tgt_hit[0] = (held_q == TG_SOUND);
   assign tgt_hit[1] = (held_q == TG_PROG);
   assign tgt_hit[2] = (held_q == TG_WB0) || (held_q == TG_WB1) || (held_q == TG_WALL);

   generate
      for (genvar g = 0; g < N_MEM; g++) begin : g_we
         assign mem_we[g] = bwr && tgt_hit[g];
      end
   endgenerate

   always_comb begin
      case (held_q)
         TG_WB0:  work_half = 2'b01;
         TG_WB1:  work_half = 2'b10;
         TG_WALL: work_half = 2'b11;
         default: work_half = 2'b00;
      endcase
   end

   assign src_rd   = bwr;
   assign mem_data = src_data;

   assert_we_onehot_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mem_we));
   assert_park_no_burst_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PARK) && !bbusy |=> !(|mem_we));
   assert_disable_stops_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |=> !(|mem_we) && (state_q == ST_IDLE));
   assert_end_flag_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      bdone && out_en && !xfer_start |=> end_flag && xfer_done);
   assert_irq_gate_R13 : assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(irq_en));
endmodule

// File: tb/paced_dma_tb.sv
module paced_dma_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dest_wr = 0, mem_split = 0, mem_sel0 = 0, prg_own = 0, out_en = 1;
   logic [2:0]  dest_in = 0;
   logic        xfer_start = 0, addr_wr = 0, irq_en = 0;
   logic [15:0] cnt_in = 0, addr_in = 0;
   logic [7:0]  src_data;
   logic        src_rd, end_flag, xfer_done, irq;
   logic [2:0]  mem_we;
   logic [1:0]  work_half;
   logic [15:0] mem_addr, cnt_out;
   logic [7:0]  mem_data;

   int checks = 0, errors = 0, cyc = 0, irq_cnt = 0;
   logic [7:0] rd_cnt = 0;
   int exp_idx = 0;
   logic [28:0] exp_q[$];
   int bst_q[$];
   logic prev_we = 0;

   always #5 clk = ~clk;

   paced_dma u_dut (
      .clk(clk), .rst_n(rst_n), .dest_wr(dest_wr), .dest_in(dest_in), .mem_split(mem_split),
      .mem_sel0(mem_sel0), .prg_own(prg_own), .out_en(out_en), .xfer_start(xfer_start),
      .cnt_in(cnt_in), .addr_wr(addr_wr), .addr_in(addr_in), .irq_en(irq_en),
      .src_data(src_data), .src_rd(src_rd), .mem_we(mem_we), .work_half(work_half),
      .mem_addr(mem_addr), .mem_data(mem_data), .cnt_out(cnt_out), .end_flag(end_flag),
      .xfer_done(xfer_done), .irq(irq)
   );

   assign src_data = rd_cnt ^ 8'h5A;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (src_rd) rd_cnt <= rd_cnt + 1'b1;
   end

   task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pop expected writes, record burst start cycles, count interrupts
   always @(negedge clk) begin
      if (rst_n) begin
         if (irq) irq_cnt++;
         if (|mem_we) begin
            if (!prev_we) bst_q.push_back(cyc);
            if (exp_q.size() == 0) check(1'b0, "R2 unexpected write", {mem_we, work_half, mem_addr, mem_data}, 0);
            else begin
               logic [28:0] e;
               e = exp_q.pop_front();
               check({mem_we, work_half, mem_addr, mem_data} == e, "R6 write item",
                     {mem_we, work_half, mem_addr, mem_data}, e);
            end
         end
         prev_we <= |mem_we;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push_writes(input logic [2:0] we, input logic [1:0] half, input logic [15:0] a0, input int n);
      for (int i = 0; i < n; i++) begin
         logic [7:0] d;
         d = 8'(exp_idx) ^ 8'h5A;
         exp_q.push_back({we, half, a0 + 16'(i), d});
         exp_idx++;
      end
   endtask

   task automatic set_dest(input logic [2:0] c);
      dest_in = c; dest_wr = 1; tick(1); dest_wr = 0; tick(1);
   endtask

   task automatic set_addr(input logic [15:0] a);
      addr_in = a; addr_wr = 1; tick(1); addr_wr = 0;
   endtask

   task automatic start(input logic [15:0] n, output int t);
      cnt_in = n; xfer_start = 1; t = cyc + 1; tick(1); xfer_start = 0;
   endtask

   task automatic next_burst(output int t);
      int w = 0;
      while (bst_q.size() == 0 && w < 2000) begin tick(1); w++; end
      if (bst_q.size() == 0) begin
         check(1'b0, "R4 burst timeout", 0, 1);
         t = -1;
      end else t = bst_q.pop_front();
   endtask

   initial begin
      int t, b1, b2, b3, tr;
      tick(5); rst_n = 1; tick(2);
      // R1
      check(cnt_out == 16'hFFFF, "R1 count reset", cnt_out, 16'hFFFF);
      check(mem_we == 0, "R1 no write", mem_we, 0);
      check(end_flag == 0, "R1 end flag", end_flag, 0);

      // sound transfer, 20 bytes: R2 R3 R4 R5 R13
      irq_en = 1;
      set_dest(3'd4); set_addr(16'h0100);
      push_writes(3'b001, 2'b00, 16'h0100, 20);
      start(16'd19, t);
      next_burst(b1); check(b1 == t + 113, "R3 first burst", b1, t + 113);
      next_burst(b2); check(b2 == b1 + 128, "R4 burst spacing", b2, b1 + 128);
      next_burst(b3); check(b3 == b2 + 128, "R5 final burst", b3, b2 + 128);
      tick(10);
      check(end_flag == 1, "R5 end flag", end_flag, 1);
      check(cnt_out == 16'hFFFF, "R5 count ones", cnt_out, 16'hFFFF);
      check(irq_cnt == 1, "R13 irq enabled", irq_cnt, 1);
      check(exp_q.size() == 0, "R5 byte total", exp_q.size(), 0);

      // program RAM parked at start: R7 R13
      irq_en = 0; prg_own = 1;
      set_dest(3'd5); set_addr(16'h0040);
      start(16'd7, t);
      tick(300);
      check(bst_q.size() == 0, "R7 parked no write", bst_q.size(), 0);
      check(end_flag == 0, "R7 end flag clear", end_flag, 0);
      push_writes(3'b010, 2'b00, 16'h0040, 8);
      prg_own = 0; tr = cyc + 1; tick(1);
      next_burst(b1); check(b1 == tr + 113, "R7 resume timing", b1, tr + 113);
      tick(10);
      check(end_flag == 1, "R7 end after resume", end_flag, 1);
      check(irq_cnt == 1, "R13 irq masked", irq_cnt, 1);

      // split work RAM banks: R9
      mem_split = 1; mem_sel0 = 1;
      set_dest(3'd7); set_addr(16'h0010);
      push_writes(3'b100, 2'b01, 16'h0010, 4);
      start(16'd3, t);
      next_burst(b1); check(b1 == t + 113, "R9 bank0 timing", b1, t + 113);
      tick(10);
      mem_sel0 = 0;
      set_dest(3'd7); set_addr(16'h0020);
      push_writes(3'b100, 2'b10, 16'h0020, 4);
      start(16'd3, t);
      next_burst(b1); check(b1 == t + 113, "R9 bank1 timing", b1, t + 113);
      tick(10);
      check(exp_q.size() == 0, "R9 bank writes", exp_q.size(), 0);

      // unsplit work RAM with ownership: R8 R10 R9
      mem_split = 0; mem_sel0 = 0;
      set_dest(3'd7); set_addr(16'h0200);
      push_writes(3'b100, 2'b11, 16'h0200, 24);
      start(16'd23, t);
      next_burst(b1); check(b1 == t + 113, "R9 whole timing", b1, t + 113);
      tick(2); mem_sel0 = 1;
      while (cyc < b1 + 10) tick(1);
      mem_sel0 = 0;
      next_burst(b2); check(b2 == b1 + 128, "R10 short park no rewind", b2, b1 + 128);
      tick(2); mem_sel0 = 1;
      tick(400);
      check(bst_q.size() == 0, "R8 owned no write", bst_q.size(), 0);
      check(cnt_out == 16'd7, "R8 count kept", cnt_out, 7);
      mem_sel0 = 0; tr = cyc + 1; tick(1);
      next_burst(b3); check(b3 == tr + 113, "R8 resume timing", b3, tr + 113);
      tick(10);
      check(end_flag == 1, "R8 end flag", end_flag, 1);

      // retarget mid-transfer: R11
      mem_split = 1; mem_sel0 = 1;
      set_dest(3'd4); set_addr(16'h0300);
      push_writes(3'b001, 2'b00, 16'h0300, 8);
      start(16'd31, t);
      next_burst(b1);
      tick(10);
      push_writes(3'b100, 2'b01, 16'h0000, 8);
      set_dest(3'd7);
      next_burst(b2); check(b2 == b1 + 128, "R11 retarget timing", b2, b1 + 128);
      tick(10);
      set_dest(3'd1);
      tick(400);
      check(bst_q.size() == 0, "R11 invalid code stops", bst_q.size(), 0);
      check(cnt_out == 16'd15, "R11 count kept", cnt_out, 15);
      check(end_flag == 0, "R11 not ended", end_flag, 0);

      // output enable drop: R12
      prg_own = 1;
      set_dest(3'd5);
      start(16'd7, t);
      tick(20);
      out_en = 0; tick(2);
      prg_own = 0; tick(300);
      check(bst_q.size() == 0, "R12 parked dropped", bst_q.size(), 0);
      cnt_in = 16'd3; xfer_start = 1; tick(1); xfer_start = 0; tick(2);
      check(cnt_out == 16'd7, "R12 start ignored", cnt_out, 7);
      out_en = 1; tick(300);
      check(bst_q.size() == 0, "R12 stays idle", bst_q.size(), 0);
      set_dest(3'd4); set_addr(16'h0400);
      push_writes(3'b001, 2'b00, 16'h0400, 8);
      start(16'd15, t);
      next_burst(b1); check(b1 == t + 113, "R12 active timing", b1, t + 113);
      tick(20);
      out_en = 0; tick(300);
      check(bst_q.size() == 0, "R12 running dropped", bst_q.size(), 0);
      out_en = 1;
      check(exp_q.size() == 0, "R6 all writes seen", exp_q.size(), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #2_000_000;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule